// File: doc/BRIEF.md
# Flash program/erase status controller

This block is the internal sequencer of a sectored NOR-style flash array. A command front end hands it already decoded requests: program one word, erase a chosen set of sectors, or erase the whole chip. The block checks each request against the protection and programming rules. It then runs the operation word by word over a simple word-wide array port, timing each word with a cycle counter. When the operation is finished it goes back to plain reads by itself.

While an operation runs, a host read returns a status word instead of array data. A ready/busy pin also shows progress. Erase is done one sector at a time. Each selected sector is first driven to all zeros, and only then set to all ones. The sector layout has eight small boot sectors and a parameterised number of large sectors. A parameter places the boot group at the top or the bottom of the address range.

Top module: `flash_status_ctrl`

## Requirements
- R1: While an operation is busy, `rdData` bit 7 reads the inverse of bit 7 of the word being programmed, or 0 during an erase. All other status bits except bit 6 read 0.
- R2: While busy, `rdData` bit 6 changes value on every cycle that `rdStrobe` is high. When the block is not busy, two consecutive reads return identical data.
- R3: `readyBusy` is low for the whole of an accepted operation and high otherwise. After completion, reads return array data at `hostAddr` with no further request.
- R4: A sector erase (`reqKind`=2) sets every word of every selected, unprotected sector to 16'hFFFF. It leaves all other words unchanged. Sector index i is bit i of `sectSel`.
- R5: A chip erase (`reqKind`=3) erases every unprotected sector, whatever `sectSel` holds.
- R6: Every word of a sector is written to 16'h0000 before any word of that sector is written to 16'hFFFF.
- R7: Sectors are numbered in ascending address order. There are NBOOT sectors of BOOT_W words and NBIG sectors of BIG_W words. With TOP_BOOT=1 the boot sectors occupy the highest addresses.
- R8: A word in a sector whose `protBits` bit is set is never written. When `wpIn` is high, the two outermost boot sectors are also never written.
- R9: A program request (`reqKind`=1) with `wordMode` low is rejected. `readyBusy` stays high and the array is unchanged.
- R10: A program request to a word that does not read 16'hFFFF is rejected, with `readyBusy` staying high.
- R11: An erase in which no selected sector is writable finishes with no array change and `readyBusy` never low.
- R12: An accepted program writes `reqData` to `reqAddr` once, after PROG_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, one cycle |
| reqKind | input | 2 | 1 program, 2 sector erase, 3 chip erase |
| reqAddr | input | AW | Word address for program |
| reqData | input | 16 | Word to program |
| sectSel | input | NSECT | Sectors chosen for sector erase |
| wordMode | input | 1 | High when the bus is in x16 mode |
| wpIn | input | 1 | Hardware guard of the two outermost boot sectors |
| protBits | input | NSECT | Software protection, one bit per sector |
| hostAddr | input | AW | Host read address |
| rdStrobe | input | 1 | Host read strobe |
| rdData | output | 16 | Array data, or the status word while busy |
| readyBusy | output | 1 | High when ready, low when busy |
| arrAddr | output | AW | Array word address |
| arrWdata | output | 16 | Array write data |
| arrWe | output | 1 | Array write strobe |
| arrRdata | input | 16 | Array read data (combinational) |

## Verification
The bench uses the top-boot layout. It erases a mix of boot and large sectors, where one selected sector is guarded by `wpIn`. If the sector map or the guard were wrong, the scoreboard would show words erased in the wrong sector, or a guarded word overwritten. The bench also tries three programs that must be rejected: one in byte mode, one to a word already written, and one to a guarded sector. Any of them going busy or changing the array would fail. It also runs an erase where every selected sector is protected, which must stay ready throughout. The array model flags any all-ones write to a word that was not zeroed first, which catches a design that skips the pre-program pass. The status checks compare two back-to-back reads: bit 6 must flip, and bit 7 must follow the programmed data.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    WR_DATA = 2'd0,
    WR_ZERO = 2'd1,
    WR_ONES = 2'd2
  } wrSel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PROG,
    ST_PRE,
    ST_ERASE,
    ST_NEXT
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   ldReq;
    logic   pickSect;
    logic   dropSect;
    logic   clrCnt;
    logic   stepCnt;
    logic   nextWord;
    logic   restartWord;
    logic   doWrite;
    wrSel_t wrSel;
    logic   busy;
    logic   eraseMode;
    logic   ownArray;
  } dpCtl_t;

endpackage

// File: rtl/fsc_sector_map.sv
module fsc_sector_map #(
  parameter int NBOOT    = 8,
  parameter int BOOT_W   = 4096,
  parameter int NBIG     = 63,
  parameter int BIG_W    = 32768,
  parameter bit TOP_BOOT = 1'b0,
  parameter int AW       = 21,
  parameter int NSECT    = 71,
  parameter int SW       = 7
) (
  input  logic [AW-1:0]    addrIn,
  input  logic [SW-1:0]    sectIn,
  output logic [SW-1:0]    sectOut,
  output logic [AW-1:0]    baseOut,
  output logic [AW-1:0]    lastOut,
  output logic [NSECT-1:0] guardMask
);
  localparam int BOOT_SH   = $clog2(BOOT_W);
  localparam int BIG_SH    = $clog2(BIG_W);
  localparam int BOOT_SPAN = NBOOT * BOOT_W;
  localparam int BIG_SPAN  = NBIG * BIG_W;

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        int a;
        int s;
        a = int'(addrIn);
        s = int'(sectIn);
        if (a < BIG_SPAN) sectOut = SW'(a >> BIG_SH);
        else              sectOut = SW'(NBIG + ((a - BIG_SPAN) >> BOOT_SH));
        if (s < NBIG) begin
          baseOut = AW'(s << BIG_SH);
          lastOut = AW'(BIG_W - 1);
        end else begin
          baseOut = AW'(BIG_SPAN + ((s - NBIG) << BOOT_SH));
          lastOut = AW'(BOOT_W - 1);
        end
      end
      assign guardMask = {2'b11, {(NSECT-2){1'b0}}};
    end else begin : g_bottom
      always_comb begin
        int a;
        int s;
        a = int'(addrIn);
        s = int'(sectIn);
        if (a < BOOT_SPAN) sectOut = SW'(a >> BOOT_SH);
        else               sectOut = SW'(NBOOT + ((a - BOOT_SPAN) >> BIG_SH));
        if (s < NBOOT) begin
          baseOut = AW'(s << BOOT_SH);
          lastOut = AW'(BOOT_W - 1);
        end else begin
          baseOut = AW'(BOOT_SPAN + ((s - NBOOT) << BIG_SH));
          lastOut = AW'(BIG_W - 1);
        end
      end
      assign guardMask = {{(NSECT-2){1'b0}}, 2'b11};
    end
  endgenerate

endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int NBOOT     = 8,
  parameter int BOOT_W    = 4096,
  parameter int NBIG      = 63,
  parameter int BIG_W     = 32768,
  parameter bit TOP_BOOT  = 1'b0,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 4,
  parameter int AW        = 21,
  parameter int NSECT     = 71,
  parameter int SW        = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [1:0]       reqKind,
  input  logic [AW-1:0]    reqAddr,
  input  logic [15:0]      reqData,
  input  logic [NSECT-1:0] sectSel,
  input  logic             wordMode,
  input  logic             wpIn,
  input  logic [NSECT-1:0] protBits,
  input  logic [AW-1:0]    hostAddr,
  input  logic             rdStrobe,
  input  logic [15:0]      arrRdata,
  output logic [AW-1:0]    arrAddr,
  output logic [15:0]      arrWdata,
  output logic             arrWe,
  output logic [15:0]      rdData,
  output logic             isProg,
  output logic             progOk,
  output logic             anyPend,
  output logic             moreSect,
  output logic             lastWord,
  output logic             cntDone
);
  localparam int CMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  opKind_t          opReg;
  logic [AW-1:0]    addrReg;
  logic [15:0]      dataReg;
  logic             modeOk;
  logic [NSECT-1:0] allowReg;
  logic [NSECT-1:0] pendMask;
  logic [SW-1:0]    curSect;
  logic [AW-1:0]    wordOfs;
  logic [CW-1:0]    cycCnt;
  logic             togBit;

  logic [AW-1:0]    opAddr;
  logic [SW-1:0]    mapSect;
  logic [AW-1:0]    mapBase;
  logic [AW-1:0]    mapLast;
  logic [NSECT-1:0] guardMask;
  logic [SW-1:0]    lowSect;
  logic [NSECT-1:0] allowNow;
  logic [NSECT-1:0] curOneHot;
  logic             statBit7;

  fsc_sector_map #(
    .NBOOT(NBOOT), .BOOT_W(BOOT_W), .NBIG(NBIG), .BIG_W(BIG_W),
    .TOP_BOOT(TOP_BOOT), .AW(AW), .NSECT(NSECT), .SW(SW)
  ) u_map (
    .addrIn(opAddr), .sectIn(curSect), .sectOut(mapSect),
    .baseOut(mapBase), .lastOut(mapLast), .guardMask(guardMask)
  );

  // lowest pending sector is served first
  always_comb begin
    logic found;
    found   = 1'b0;
    lowSect = '0;
    for (int i = 0; i < NSECT; i++) begin
      if (!found && pendMask[i]) begin
        lowSect = SW'(i);
        found   = 1'b1;
      end
    end
  end

  assign allowNow  = ~(protBits | (wpIn ? guardMask : '0));
  assign curOneHot = NSECT'(1) << curSect;
  assign isProg    = (opReg == OP_PROG);
  assign opAddr    = isProg ? addrReg : (mapBase + wordOfs);
  assign arrAddr   = ctl.ownArray ? opAddr : hostAddr;
  assign arrWe     = ctl.doWrite;

  always_comb begin
    case (ctl.wrSel)
      WR_ZERO: arrWdata = 16'h0000;
      WR_ONES: arrWdata = 16'hFFFF;
      default: arrWdata = dataReg;
    endcase
  end

  assign progOk   = modeOk && allowReg[mapSect] && (arrRdata == 16'hFFFF);
  assign anyPend  = |pendMask;
  assign moreSect = |(pendMask & ~curOneHot);
  assign lastWord = (wordOfs == mapLast);
  assign cntDone  = (cycCnt == (ctl.eraseMode ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1)));

  assign statBit7 = isProg ? ~dataReg[7] : 1'b0;
  assign rdData   = ctl.busy ? {8'h00, statBit7, togBit, 6'b000000} : arrRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg    <= OP_NONE;
      addrReg  <= '0;
      dataReg  <= '0;
      modeOk   <= 1'b0;
      allowReg <= '0;
      pendMask <= '0;
      curSect  <= '0;
      wordOfs  <= '0;
      cycCnt   <= '0;
      togBit   <= 1'b0;
    end else begin
      if (ctl.ldReq) begin
        opReg    <= opKind_t'(reqKind);
        addrReg  <= reqAddr;
        dataReg  <= reqData;
        modeOk   <= wordMode;
        allowReg <= allowNow;
        pendMask <= ((reqKind == OP_CHIP) ? {NSECT{1'b1}} : sectSel) & allowNow;
      end
      if (ctl.dropSect) pendMask[curSect] <= 1'b0;

      if (ctl.pickSect) begin
        curSect <= lowSect;
        wordOfs <= '0;
      end else if (ctl.restartWord) begin
        wordOfs <= '0;
      end else if (ctl.nextWord) begin
        wordOfs <= wordOfs + 1'b1;
      end

      if (ctl.clrCnt)       cycCnt <= '0;
      else if (ctl.stepCnt) cycCnt <= cycCnt + 1'b1;

      if (ctl.busy && rdStrobe) togBit <= ~togBit;
    end
  end

  // R8: every array write lands in a sector writable for this request
  p_write_allowed_r8: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> allowReg[mapSect]);

  // R7: erase walk never leaves the current sector
  p_ofs_in_sector_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && !isProg) |-> (wordOfs <= mapLast));

  // R2: toggle bit frozen when no operation runs
  p_tog_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busy |=> $stable(togBit));

endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       isProg,
  input  logic       progOk,
  input  logic       anyPend,
  input  logic       moreSect,
  input  logic       lastWord,
  input  logic       cntDone,
  output dpCtl_t     ctl
);
  ctlState_t state;
  ctlState_t nxt;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid && (reqKind != OP_NONE)) begin
          ctl.ldReq = 1'b1;
          nxt       = ST_CHECK;
        end
      end
      ST_CHECK: begin
        ctl.ownArray = 1'b1;
        if (isProg) begin
          if (progOk) begin
            ctl.clrCnt = 1'b1;
            nxt        = ST_PROG;
          end else begin
            nxt = ST_IDLE;
          end
        end else if (anyPend) begin
          ctl.pickSect = 1'b1;
          ctl.clrCnt   = 1'b1;
          nxt          = ST_PRE;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_PROG: begin
        ctl.ownArray = 1'b1;
        ctl.busy     = 1'b1;
        ctl.stepCnt  = 1'b1;
        if (cntDone) begin
          ctl.doWrite = 1'b1;
          ctl.wrSel   = WR_DATA;
          nxt         = ST_IDLE;
        end
      end
      ST_PRE: begin
        ctl.ownArray = 1'b1;
        ctl.busy     = 1'b1;
        ctl.stepCnt  = 1'b1;
        if (cntDone) begin
          ctl.doWrite = 1'b1;
          ctl.wrSel   = WR_ZERO;
          ctl.clrCnt  = 1'b1;
          if (lastWord) begin
            ctl.restartWord = 1'b1;
            nxt             = ST_ERASE;
          end else begin
            ctl.nextWord = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        ctl.ownArray  = 1'b1;
        ctl.busy      = 1'b1;
        ctl.eraseMode = 1'b1;
        ctl.stepCnt   = 1'b1;
        if (cntDone) begin
          ctl.doWrite = 1'b1;
          ctl.wrSel   = WR_ONES;
          ctl.clrCnt  = 1'b1;
          if (lastWord) begin
            ctl.dropSect = 1'b1;
            nxt          = moreSect ? ST_NEXT : ST_IDLE;
          end else begin
            ctl.nextWord = 1'b1;
          end
        end
      end
      ST_NEXT: begin
        ctl.ownArray = 1'b1;
        ctl.busy     = 1'b1;
        ctl.pickSect = 1'b1;
        ctl.clrCnt   = 1'b1;
        nxt          = ST_PRE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  // R3: busy only drops on the cycle after the final array write
  p_busy_ends_on_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.busy) |-> $past(ctl.doWrite));

  // R9 / R10: a refused program never turns busy
  p_reject_stays_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && isProg && !progOk) |=> !ctl.busy);

  // R11: an erase with nothing writable returns straight to idle
  p_empty_erase_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !isProg && !anyPend) |=> (state == ST_IDLE));

  // R6: erase phase is only reached through the pre-program phase
  p_erase_after_pre_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE) |-> ($past(state) == ST_ERASE || $past(state) == ST_PRE));

endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int NBOOT     = 8,
  parameter int BOOT_W    = 4096,
  parameter int NBIG      = 63,
  parameter int BIG_W     = 32768,
  parameter bit TOP_BOOT  = 1'b0,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 4,
  localparam int NSECT    = NBOOT + NBIG,
  localparam int SW       = $clog2(NSECT),
  localparam int AW       = $clog2(NBOOT * BOOT_W + NBIG * BIG_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [AW-1:0]    reqAddr,
  input  logic [15:0]      reqData,
  input  logic [NSECT-1:0] sectSel,
  input  logic             wordMode,
  input  logic             wpIn,
  input  logic [NSECT-1:0] protBits,
  input  logic [AW-1:0]    hostAddr,
  input  logic             rdStrobe,
  output logic [15:0]      rdData,
  output logic             readyBusy,
  output logic [AW-1:0]    arrAddr,
  output logic [15:0]      arrWdata,
  output logic             arrWe,
  input  logic [15:0]      arrRdata
);
  dpCtl_t ctl;
  logic   isProg, progOk, anyPend, moreSect, lastWord, cntDone;

  fsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .isProg(isProg), .progOk(progOk), .anyPend(anyPend), .moreSect(moreSect),
    .lastWord(lastWord), .cntDone(cntDone), .ctl(ctl)
  );

  fsc_datapath #(
    .NBOOT(NBOOT), .BOOT_W(BOOT_W), .NBIG(NBIG), .BIG_W(BIG_W),
    .TOP_BOOT(TOP_BOOT), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .AW(AW), .NSECT(NSECT), .SW(SW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqData(reqData), .sectSel(sectSel), .wordMode(wordMode), .wpIn(wpIn),
    .protBits(protBits), .hostAddr(hostAddr), .rdStrobe(rdStrobe),
    .arrRdata(arrRdata), .arrAddr(arrAddr), .arrWdata(arrWdata), .arrWe(arrWe),
    .rdData(rdData), .isProg(isProg), .progOk(progOk), .anyPend(anyPend),
    .moreSect(moreSect), .lastWord(lastWord), .cntDone(cntDone)
  );

  assign readyBusy = ~ctl.busy;

  // R3: no array write while the pin reports ready
  p_write_while_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> !readyBusy);

endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSECT = 11;
  localparam int AW = 6;
  localparam int WORDS = 56;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [NSECT-1:0] sectSel = '0;
  logic wordMode = 1'b1;
  logic wpIn = 1'b0;
  logic [NSECT-1:0] protBits = '0;
  logic [AW-1:0] hostAddr;
  logic rdStrobe = 1'b0;
  logic [15:0] rdData;
  logic readyBusy;
  logic [AW-1:0] arrAddr;
  logic [15:0] arrWdata;
  logic arrWe;
  logic [15:0] arrRdata;

  logic [15:0] mem [0:63];
  logic        zeroed [0:63];
  logic [15:0] refMem [0:63];

  int nChecks = 0;
  int nFails = 0;
  bit ended = 1'b0;

  int qAddr[$];
  logic [15:0] qVal[$];
  string qTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_ctrl #(
    .NBOOT(8), .BOOT_W(4), .NBIG(3), .BIG_W(8), .TOP_BOOT(1'b1),
    .PROG_CYC(6), .ERASE_CYC(3)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqData(reqData), .sectSel(sectSel),
    .wordMode(wordMode), .wpIn(wpIn), .protBits(protBits),
    .hostAddr(hostAddr), .rdStrobe(rdStrobe), .rdData(rdData),
    .readyBusy(readyBusy), .arrAddr(arrAddr), .arrWdata(arrWdata),
    .arrWe(arrWe), .arrRdata(arrRdata)
  );

  assign arrRdata = mem[arrAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // array model; R6 watch: an all-ones write needs a prior zero write
  always @(posedge clk) begin
    if (arrWe) begin
      if (arrWdata == 16'hFFFF) begin
        check(zeroed[arrAddr], "R6 ones before zero", 0, 1);
        zeroed[arrAddr] <= 1'b0;
      end else if (arrWdata == 16'h0000) begin
        zeroed[arrAddr] <= 1'b1;
      end
      mem[arrAddr] <= arrWdata;
    end
  end

  // scoreboard monitor: owns hostAddr, pops expected words
  initial begin
    hostAddr = '0;
    forever begin
      @(negedge clk);
      if (qAddr.size() > 0) begin
        int a;
        logic [15:0] v;
        string t;
        a = qAddr.pop_front();
        v = qVal.pop_front();
        t = qTag.pop_front();
        hostAddr = AW'(a);
        #1;
        check(rdData == v, t, rdData, v);
      end
    end
  end

  function automatic int sBase(input int i);
    return (i < 3) ? 8 * i : 24 + 4 * (i - 3);
  endfunction
  function automatic int sSize(input int i);
    return (i < 3) ? 8 : 4;
  endfunction
  function automatic int sOf(input int a);
    return (a < 24) ? a / 8 : 3 + (a - 24) / 4;
  endfunction
  function automatic bit writable(input int i, input bit wp, input logic [NSECT-1:0] pb);
    return !pb[i] && !(wp && i >= 9);
  endfunction

  task automatic pushAll(input string tag);
    for (int a = 0; a < WORDS; a++) begin
      qAddr.push_back(a);
      qVal.push_back(refMem[a]);
      qTag.push_back(tag);
    end
    wait (qAddr.size() == 0);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] k, input int a, input logic [15:0] d,
                       input logic [NSECT-1:0] sel);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = AW'(a); reqData = d; sectSel = sel;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectIdle(input string tag);
    bit stayed;
    stayed = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!readyBusy) stayed = 1'b0;
    end
    check(stayed, tag, 0, 1);
  endtask

  task automatic runBusy(input int exp7, input string tag);
    logic [15:0] r0, r1;
    int n;
    n = 0;
    while (readyBusy && n < 4) begin @(negedge clk); n++; end
    check(!readyBusy, {tag, " R3 busy low"}, readyBusy, 0);
    rdStrobe = 1'b1;
    #1 r0 = rdData;
    @(negedge clk);
    #1 r1 = rdData;
    rdStrobe = 1'b0;
    check(r0[6] != r1[6], {tag, " R2 toggle"}, r1[6], !r0[6]);
    check(r0[7] == exp7[0] && r0[5:0] == 6'd0 && r0[15:8] == 8'd0,
          {tag, " R1 status"}, r0, {8'h00, exp7[0], r0[6], 6'b0});
    n = 0;
    while (!readyBusy && n < 3000) begin @(negedge clk); n++; end
    check(readyBusy, {tag, " R3 ready again"}, readyBusy, 1);
    rdStrobe = 1'b1;
    #1 r0 = rdData;
    @(negedge clk);
    #1 r1 = rdData;
    rdStrobe = 1'b0;
    check(r0 == r1, {tag, " R2 steady after done"}, r1, r0);
  endtask

  task automatic refErase(input logic [NSECT-1:0] sel, input bit wp, input logic [NSECT-1:0] pb);
    for (int i = 0; i < NSECT; i++)
      if (sel[i] && writable(i, wp, pb))
        for (int w = 0; w < sSize(i); w++) refMem[sBase(i) + w] = 16'hFFFF;
  endtask

  task automatic progOk(input int a, input logic [15:0] d, input string tag);
    issue(2'd1, a, d, '0);
    runBusy(int'(~d[7]), tag);
    refMem[a] = d;
  endtask

  initial begin
    for (int a = 0; a < 64; a++) begin
      mem[a] = 16'hFFFF; refMem[a] = 16'hFFFF; zeroed[a] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(readyBusy == 1'b1, "R3 reset ready", readyBusy, 1);
    pushAll("R3 reset reads array");

    // R12 / R1: accepted program, data bit 7 = 0 gives status bit 7 = 1
    progOk(5, 16'h1234, "R12 prog 5");
    pushAll("R12 prog 5 array");

    // R10: word already written
    issue(2'd1, 5, 16'h00FF, '0);
    expectIdle("R10 not-erased reject stays ready");
    pushAll("R10 array unchanged");

    // R9: byte mode
    wordMode = 1'b0;
    issue(2'd1, 6, 16'h4321, '0);
    expectIdle("R9 byte-mode reject stays ready");
    wordMode = 1'b1;
    pushAll("R9 array unchanged");

    // R8: hardware guard on outermost boot sector, then allowed
    wpIn = 1'b1;
    issue(2'd1, 50, 16'h00A0, '0);
    expectIdle("R8 guarded program stays ready");
    pushAll("R8 guarded word unchanged");
    wpIn = 1'b0;
    progOk(50, 16'h00A0, "R12 prog 50");

    // R8: software protection bit on sector 3 (addr 24..27)
    protBits = 11'b000_0000_1000;
    issue(2'd1, 25, 16'h7777, '0);
    expectIdle("R8 soft-protected program stays ready");
    protBits = '0;
    pushAll("R8 soft-protected word unchanged");

    progOk(9, 16'h5555, "R12 prog 9");
    progOk(29, 16'hAAAA, "R12 prog 29");
    progOk(52, 16'h0F0F, "R12 prog 52");
    progOk(16, 16'h1111, "R12 prog 16");

    // R4 / R7 / R8: erase sectors 1, 4, 10 with guard on
    wpIn = 1'b1;
    issue(2'd2, 0, 16'h0, 11'b100_0001_0010);
    runBusy(0, "R4 sector erase");
    refErase(11'b100_0001_0010, 1'b1, '0);
    pushAll("R4 R7 sector erase result");

    // R11: only guarded sector selected
    issue(2'd2, 0, 16'h0, 11'b100_0000_0000);
    expectIdle("R11 all-protected erase stays ready");
    pushAll("R11 array unchanged");

    // R5: chip erase, guard on, sector 0 software-protected
    protBits = 11'b000_0000_0001;
    issue(2'd3, 0, 16'h0, '0);
    runBusy(0, "R5 chip erase guarded");
    refErase('1, 1'b1, 11'b000_0000_0001);
    pushAll("R5 chip erase guarded result");

    // R5: chip erase, nothing protected
    protBits = '0;
    wpIn = 1'b0;
    issue(2'd3, 0, 16'h0, 11'b000_0000_0001);
    runBusy(0, "R5 chip erase full");
    refErase('1, 1'b0, '0);
    pushAll("R5 chip erase full result");

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

endmodule